// File: doc/BRIEF.md
# I2C Target Interface with Own-Address Match

This block lets a chip answer on a two-wire I2C bus as a target with a 7-bit address. Both bus lines are brought into the system clock domain, cleaned by a short glitch filter and watched for START, repeated START and STOP. The first byte after every START is compared with a programmable own address. A hit is acknowledged. A miss leaves the block silent until the next START.

After a write address, each data byte is shifted in most significant bit first and handed to local logic through a one-byte holding register. After a read address, the block asks local logic for a byte and shifts it out most significant bit first while the master clocks. Whenever local logic has to act, the block holds SCL low. It lets SCL go when local logic pulses a release input.

The outputs are open-drain enables: a 1 on `sclOe` or `sdaOe` means the block pulls that line low. An optional general-call acceptance answers a write to address 0x00.

Top module: `i2c_target`

## Requirements
- R1: After reset, `sclOe` and `sdaOe` are 0, and `irq`, `overflow`, `rxValid` and `txReq` are 0.
- R2: The first byte after a START or a repeated START is compared with `ownAddr` (bits 7..1 of the byte are the address, bit 0 is the direction, 1 = read). On a match the block pulls SDA low through the following acknowledge clock, `addrByte` holds the whole byte, and `irq` pulses for one cycle.
- R3: On an address miss the block leaves SDA released during the acknowledge clock. It raises no `irq`, and it neither acknowledges nor reports any later byte until the next START or repeated START.
- R4: Byte 0x00 (address 0, write) is acknowledged only while `gcEnable` is 1. Byte 0x01 (address 0, read) is never acknowledged unless `ownAddr` is 0.
- R5: In a write transfer, bits are sampled on rising SCL, most significant bit first. Each accepted byte appears on `rxByte` with a one-cycle `rxValid` pulse and an `irq` pulse, and it is acknowledged.
- R6: After every accepted write byte, and before every byte to be sent, the block holds SCL low. It keeps holding it, however long that takes, until `relSet` pulses.
- R7: In a read transfer, `txReq` pulses once for each byte needed. `txByte` is captured at the releasing `relSet` pulse and driven out most significant bit first. The block changes its SDA drive only while SCL is low.
- R8: A master ACK (SDA low) after a transmitted byte leads to another `txReq`. A master NACK makes the block release SDA and stay idle until the next START.
- R9: If a write byte completes while the previous byte has not been taken with `rxRead`, that byte is not acknowledged and `overflow` is set. `rxByte` keeps the older byte. `rxRead` clears `overflow`.
- R10: After a STOP the block is idle: clock pulses without a new START draw no acknowledge.
- R11: A low pulse on SDA shorter than `FILT_LEN` system clocks is filtered out and is not taken as a START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sensed level of the SCL line |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclOe | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaOe | output | 1 | 1 pulls SDA low |
| ownAddr | input | 7 | Own 7-bit target address |
| gcEnable | input | 1 | Accept write to address 0 |
| relSet | input | 1 | Pulse: release a held SCL |
| txByte | input | 8 | Byte to transmit, captured at release |
| txReq | output | 1 | Pulse: a byte to transmit is needed |
| rxRead | input | 1 | Pulse: local logic has taken `rxByte` |
| rxByte | output | 8 | Last accepted write byte |
| rxValid | output | 1 | Pulse: new byte on `rxByte` |
| addrByte | output | 8 | Last matched address byte with direction bit |
| overflow | output | 1 | A byte arrived before the previous one was read |
| irq | output | 1 | Pulse on address match and on each accepted byte |

## Verification
The assertions assume a well-formed bus. SDA moves while SCL is high only to make a START or a STOP, and no START or STOP is issued while the block holds SCL low. They also assume that `relSet` arrives only from local logic that reacts to a stretch. The bench master keeps every bus level stable for a quarter period of 16 system clocks, far above the filter length. It always waits for SCL to read high before it continues. The responder pulses `relSet` only while `sclOe` is 1. The single deliberate bus violation is a two-cycle SDA glitch, which exercises the filter.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clrCnt;
    logic bitIn;
    logic loadTx;
    logic shiftTx;
    logic latchRx;
    logic latchAddr;
    logic setOvf;
  } dpCtl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_RXB, S_RACK, S_TXW, S_TXB, S_TACK
  } tgtState_t;
endpackage

// File: rtl/i2c_tgt_filter.sv
module i2c_tgt_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  localparam int FCW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [1:0]     syncQ;
  logic [FCW-1:0] agreeCnt;
  logic           filtQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      agreeCnt <= '0;
      filtQ    <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], lineIn};
      if (syncQ[1] == filtQ) begin
        agreeCnt <= '0;
      end else if (agreeCnt == FCW'(FILT_LEN - 1)) begin
        filtQ    <= syncQ[1];
        agreeCnt <= '0;
      end else begin
        agreeCnt <= agreeCnt + 1'b1;
      end
    end
  end

  assign lineOut = filtQ;
endmodule

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     ctl,
  input  logic       sdaF,
  input  logic [6:0] ownAddr,
  input  logic       gcEnable,
  input  logic [7:0] txByte,
  input  logic       rxRead,
  output logic       cntFull,
  output logic       addrHit,
  output logic       addrRw,
  output logic       rxFull,
  output logic       txNext,
  output logic [7:0] rxByte,
  output logic       rxValid,
  output logic [7:0] addrByte,
  output logic       overflow
);
  logic [CNT_W-1:0] bitCnt;
  logic [7:0]       rxShift;
  logic [6:0]       txRest;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxShift  <= '0;
      txRest   <= '0;
      rxByte   <= '0;
      rxFull   <= 1'b0;
      rxValid  <= 1'b0;
      addrByte <= '0;
      overflow <= 1'b0;
    end else begin
      rxValid <= ctl.latchRx;
      if (ctl.clrCnt)     bitCnt <= '0;
      else if (ctl.bitIn) bitCnt <= bitCnt + 1'b1;
      if (ctl.bitIn)     rxShift <= {rxShift[6:0], sdaF};
      if (ctl.loadTx)       txRest <= txByte[6:0];
      else if (ctl.shiftTx) txRest <= {txRest[5:0], 1'b0};
      if (ctl.latchAddr) addrByte <= rxShift;
      if (ctl.latchRx) begin
        rxByte <= rxShift;
        rxFull <= 1'b1;
      end else if (rxRead) begin
        rxFull <= 1'b0;
      end
      if (ctl.setOvf)   overflow <= 1'b1;
      else if (rxRead)  overflow <= 1'b0;
    end
  end

  assign cntFull = (bitCnt == CNT_W'(BYTE_BITS));
  assign addrHit = (rxShift[7:1] == ownAddr) || (gcEnable && rxShift == 8'h00);
  assign addrRw  = addrByte[0];
  assign txNext  = txRest[6];
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclF,
  input  logic   sdaF,
  input  logic   relSet,
  input  logic   cntFull,
  input  logic   addrHit,
  input  logic   addrRw,
  input  logic   rxFull,
  input  logic   txFirst,
  input  logic   txNext,
  output dpCtl_t ctl,
  output logic   sclOe,
  output logic   sdaOe,
  output logic   txReq,
  output logic   irq
);
  tgtState_t st;
  logic sclP, sdaP, relBit, mAck;
  logic sclRise, sclFall, startC, stopC, relNow;

  assign sclRise = sclF & ~sclP;
  assign sclFall = ~sclF & sclP;
  assign startC  = sclF & sclP & sdaP & ~sdaF;
  assign stopC   = sclF & sclP & ~sdaP & sdaF;
  assign relNow  = relSet & ~relBit;

  always_comb begin
    ctl = '0;
    if (startC) begin
      ctl.clrCnt = 1'b1;
    end else if (!stopC) begin
      case (st)
        S_ADDR: begin
          ctl.bitIn     = sclRise;
          ctl.latchAddr = sclFall & cntFull & addrHit;
        end
        S_AACK, S_RACK: ctl.clrCnt = sclFall;
        S_RXB: begin
          ctl.bitIn   = sclRise;
          ctl.latchRx = sclFall & cntFull & ~rxFull;
          ctl.setOvf  = sclFall & cntFull & rxFull;
        end
        S_TXW: begin
          ctl.loadTx = relNow;
          ctl.clrCnt = relNow;
        end
        S_TXB: begin
          ctl.bitIn   = sclRise;
          ctl.shiftTx = sclFall & ~cntFull;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= S_IDLE;
      sclP   <= 1'b1;
      sdaP   <= 1'b1;
      relBit <= 1'b1;
      sdaOe  <= 1'b0;
      mAck   <= 1'b0;
      txReq  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      sclP  <= sclF;
      sdaP  <= sdaF;
      txReq <= 1'b0;
      irq   <= 1'b0;
      if (relSet) relBit <= 1'b1;
      if (startC) begin
        st <= S_ADDR; sdaOe <= 1'b0; relBit <= 1'b1;
      end else if (stopC) begin
        st <= S_IDLE; sdaOe <= 1'b0; relBit <= 1'b1;
      end else begin
        case (st)
          S_ADDR: if (sclFall && cntFull) begin
            if (addrHit) begin
              st <= S_AACK; sdaOe <= 1'b1; irq <= 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end
          S_AACK: if (sclFall) begin
            sdaOe <= 1'b0;
            if (addrRw) begin
              st <= S_TXW; relBit <= 1'b0; txReq <= 1'b1;
            end else begin
              st <= S_RXB;
            end
          end
          S_RXB: if (sclFall && cntFull) begin
            if (rxFull) begin
              st <= S_IDLE; sdaOe <= 1'b0;
            end else begin
              st <= S_RACK; sdaOe <= 1'b1; relBit <= 1'b0; irq <= 1'b1;
            end
          end
          S_RACK: if (sclFall) begin
            sdaOe <= 1'b0; st <= S_RXB;
          end
          S_TXW: if (relNow) begin
            sdaOe <= ~txFirst; st <= S_TXB;
          end
          S_TXB: if (sclFall) begin
            if (cntFull) begin
              sdaOe <= 1'b0; st <= S_TACK;
            end else begin
              sdaOe <= ~txNext;
            end
          end
          S_TACK: begin
            if (sclRise) begin
              mAck <= ~sdaF;
            end else if (sclFall) begin
              if (mAck) begin
                st <= S_TXW; relBit <= 1'b0; txReq <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign sclOe = ~relBit;
endmodule

// File: rtl/i2c_target.sv
module i2c_target
  import i2c_tgt_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  input  logic [6:0] ownAddr,
  input  logic       gcEnable,
  input  logic       relSet,
  input  logic [7:0] txByte,
  output logic       txReq,
  input  logic       rxRead,
  output logic [7:0] rxByte,
  output logic       rxValid,
  output logic [7:0] addrByte,
  output logic       overflow,
  output logic       irq
);
  logic [1:0] rawLines, cleanLines;
  dpCtl_t     ctl;
  logic       cntFull, addrHit, addrRw, rxFull, txNext;

  assign rawLines = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : gLine
    i2c_tgt_filter #(.FILT_LEN(FILT_LEN)) uFilt (
      .clk(clk), .rstN(rstN), .lineIn(rawLines[g]), .lineOut(cleanLines[g])
    );
  end

  i2c_tgt_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sclF(cleanLines[1]), .sdaF(cleanLines[0]),
    .relSet(relSet), .cntFull(cntFull), .addrHit(addrHit), .addrRw(addrRw),
    .rxFull(rxFull), .txFirst(txByte[7]), .txNext(txNext), .ctl(ctl),
    .sclOe(sclOe), .sdaOe(sdaOe), .txReq(txReq), .irq(irq)
  );

  i2c_tgt_dp uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaF(cleanLines[0]), .ownAddr(ownAddr),
    .gcEnable(gcEnable), .txByte(txByte), .rxRead(rxRead), .cntFull(cntFull),
    .addrHit(addrHit), .addrRw(addrRw), .rxFull(rxFull), .txNext(txNext),
    .rxByte(rxByte), .rxValid(rxValid), .addrByte(addrByte), .overflow(overflow)
  );
endmodule

// File: rtl/i2c_target_chk.sv
module i2c_target_chk (
  input logic clk,
  input logic rstN,
  input logic sclOe,
  input logic sdaOe,
  input logic rxValid,
  input logic txReq,
  input logic irq,
  input logic overflow,
  input logic relSet
);
  // R6
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclOe && !relSet) |=> sclOe);

  // R5
  rx_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (sdaOe && sclOe));

  // R9
  ovf_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> (!sdaOe && !rxValid));

  // R7
  tx_stretch_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReq |-> (sclOe && !sdaOe));

  // R2
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R7
  req_valid_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxValid, txReq}));
endmodule

bind i2c_target i2c_target_chk uChk (
  .clk(clk), .rstN(rstN), .sclOe(sclOe), .sdaOe(sdaOe), .rxValid(rxValid),
  .txReq(txReq), .irq(irq), .overflow(overflow), .relSet(relSet)
);

// File: tb/i2c_target_test.sv
module i2c_target_test;
  localparam int Q    = 16;
  localparam int HOLD = 40;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclOe, sdaOe, txReq, rxValid, overflow, irq;
  logic relSet = 1'b0, rxRead = 1'b0, gcEnable = 1'b0;
  logic [7:0] txByte = 8'h00, rxByte, addrByte;
  logic [6:0] ownAddr = OWN;
  wire sclBus = mScl & ~sclOe;
  wire sdaBus = mSda & ~sdaOe;

  int nChecks = 0, nFail = 0;
  int rxCnt = 0, txIdx = 0, irqCnt = 0, stretchCnt = 0, holdCnt = 0, sdaViol = 0;
  logic autoRel = 1'b1, autoRead = 1'b1, manRel = 1'b0, manRead = 1'b0;
  logic [7:0] rxLog [0:15];
  logic [7:0] txData [0:3];
  logic done = 1'b0;

  always #4 clk = ~clk;

  i2c_target uut (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus), .sclOe(sclOe),
    .sdaOe(sdaOe), .ownAddr(ownAddr), .gcEnable(gcEnable), .relSet(relSet),
    .txByte(txByte), .txReq(txReq), .rxRead(rxRead), .rxByte(rxByte),
    .rxValid(rxValid), .addrByte(addrByte), .overflow(overflow), .irq(irq)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // local-logic responder and monitors
  initial begin
    logic prevSclHigh, prevSdaOe;
    prevSclHigh = 1'b1; prevSdaOe = 1'b0;
    forever begin
      @(negedge clk);
      relSet = 1'b0; rxRead = 1'b0;
      if (rstN) begin
        if (rxValid) begin rxLog[rxCnt % 16] = rxByte; rxCnt++; end
        if (txReq) begin txByte = txData[txIdx % 4]; txIdx++; end
        if (irq) irqCnt++;
        if (prevSclHigh && sclBus && (sdaOe != prevSdaOe)) sdaViol++;
        prevSclHigh = sclBus; prevSdaOe = sdaOe;
        if (manRead) begin rxRead = 1'b1; manRead = 1'b0; end
        if (sclOe) begin
          holdCnt++;
          if (autoRel && holdCnt == HOLD) begin
            relSet = 1'b1; rxRead = autoRead; stretchCnt++;
          end else if (manRel) begin
            relSet = 1'b1; rxRead = autoRead; manRel = 1'b0; stretchCnt++;
          end
        end else begin
          holdCnt = 0;
        end
      end
    end
  end

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic sclUp();
    mScl = 1'b1;
    while (!sclBus) @(negedge clk);
  endtask

  task automatic mStart();
    mSda = 1'b1; sclUp(); waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic mRestart();
    mSda = 1'b1; waitQ();
    sclUp(); waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic mStop();
    mSda = 1'b0; waitQ();
    sclUp(); waitQ();
    mSda = 1'b1; waitQ();
  endtask

  task automatic mBit(input logic b, output logic r);
    mSda = b; waitQ();
    sclUp(); waitQ();
    r = sdaBus; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic mWrite(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) mBit(d[i], r);
    mBit(1'b1, r);
    ack = ~r;
  endtask

  task automatic mRead(input logic ackIt, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin mBit(1'b1, r); d[i] = r; end
    mBit(~ackIt, r);
  endtask

  task automatic testReset();
    chk(sclOe == 1'b0 && sdaOe == 1'b0, "R1 lines released", {sclOe, sdaOe}, 0);
    chk(irq == 1'b0 && overflow == 1'b0 && rxValid == 1'b0 && txReq == 1'b0,
        "R1 strobes idle", {irq, overflow, rxValid, txReq}, 0);
  endtask

  task automatic testWrite();
    logic ack;
    int irq0, st0, rx0;
    irq0 = irqCnt; st0 = stretchCnt; rx0 = rxCnt;
    mStart();
    mWrite({OWN, 1'b0}, ack);
    chk(ack, "R2 address ack", ack, 1);
    chk(addrByte == {OWN, 1'b0}, "R2 addrByte", addrByte, {OWN, 1'b0});
    chk(irqCnt == irq0 + 1, "R2 irq on match", irqCnt - irq0, 1);
    mWrite(8'hC3, ack);
    chk(ack, "R5 data ack 1", ack, 1);
    mWrite(8'h3C, ack);
    chk(ack, "R5 data ack 2", ack, 1);
    mStop();
    chk(rxCnt == rx0 + 2, "R5 byte count", rxCnt - rx0, 2);
    chk(rxLog[rx0 % 16] == 8'hC3 && rxLog[(rx0 + 1) % 16] == 8'h3C, "R5 byte values",
        {rxLog[rx0 % 16], rxLog[(rx0 + 1) % 16]}, 16'hC33C);
    chk(irqCnt == irq0 + 3, "R5 irq per byte", irqCnt - irq0, 3);
    chk(stretchCnt == st0 + 2, "R6 stretch per byte", stretchCnt - st0, 2);
  endtask

  task automatic testMiss();
    logic ack;
    int irq0, rx0;
    irq0 = irqCnt; rx0 = rxCnt;
    mStart();
    mWrite({7'h22, 1'b0}, ack);
    chk(!ack, "R3 miss nack", ack, 0);
    mWrite(8'h00, ack);
    chk(!ack, "R3 later byte ignored", ack, 0);
    chk(irqCnt == irq0 && rxCnt == rx0, "R3 no report", irqCnt - irq0 + rxCnt - rx0, 0);
    mRestart();
    mWrite({OWN, 1'b0}, ack);
    chk(ack, "R2 restart match", ack, 1);
    mWrite(8'h11, ack);
    chk(ack && rxLog[rx0 % 16] == 8'h11, "R2 data after restart", rxLog[rx0 % 16], 8'h11);
    mStop();
  endtask

  task automatic testRead();
    logic ack;
    logic [7:0] d;
    int tx0;
    tx0 = txIdx;
    txData[tx0 % 4] = 8'hA5; txData[(tx0 + 1) % 4] = 8'h0F;
    mStart();
    mWrite({OWN, 1'b1}, ack);
    chk(ack, "R2 read address ack", ack, 1);
    mRead(1'b1, d);
    chk(d == 8'hA5, "R7 first byte", d, 8'hA5);
    mRead(1'b0, d);
    chk(d == 8'h0F, "R8 byte after master ack", d, 8'h0F);
    chk(txIdx == tx0 + 2, "R8 request count", txIdx - tx0, 2);
    mRead(1'b0, d);
    chk(d == 8'hFF && txIdx == tx0 + 2, "R8 idle after nack", d, 8'hFF);
    mStop();
    chk(sdaViol == 0, "R7 SDA moves only with SCL low", sdaViol, 0);
  endtask

  task automatic testGenCall();
    logic ack;
    gcEnable = 1'b0;
    mStart(); mWrite(8'h00, ack); mStop();
    chk(!ack, "R4 general call off", ack, 0);
    gcEnable = 1'b1;
    mStart(); mWrite(8'h01, ack); mStop();
    chk(!ack, "R4 general call read refused", ack, 0);
    mStart(); mWrite(8'h00, ack);
    chk(ack, "R4 general call on", ack, 1);
    mWrite(8'h77, ack);
    chk(ack && rxByte == 8'h77, "R4 general call data", rxByte, 8'h77);
    mStop();
    gcEnable = 1'b0;
  endtask

  task automatic testStretch();
    logic ack;
    autoRel = 1'b0;
    mStart();
    mWrite({OWN, 1'b0}, ack);
    fork
      mWrite(8'h99, ack);
      begin
        while (!sclOe) @(negedge clk);
        repeat (300) @(negedge clk);
        chk(sclOe && !sclBus, "R6 hold until release", sclOe, 1);
        manRel = 1'b1;
      end
    join
    chk(ack && rxByte == 8'h99, "R6 byte after release", rxByte, 8'h99);
    mStop();
    autoRel = 1'b1;
  endtask

  task automatic testOverflow();
    logic ack;
    autoRead = 1'b0;
    mStart();
    mWrite({OWN, 1'b0}, ack);
    mWrite(8'h12, ack);
    chk(ack, "R9 first byte ack", ack, 1);
    mWrite(8'h34, ack);
    chk(!ack, "R9 unread byte nack", ack, 0);
    chk(overflow == 1'b1, "R9 overflow set", overflow, 1);
    chk(rxByte == 8'h12, "R9 older byte kept", rxByte, 8'h12);
    mStop();
    manRead = 1'b1;
    repeat (4) @(negedge clk);
    chk(overflow == 1'b0, "R9 overflow cleared", overflow, 0);
    autoRead = 1'b1;
  endtask

  task automatic testIdle();
    logic ack;
    mScl = 1'b0; waitQ();
    mWrite({OWN, 1'b0}, ack);
    chk(!ack, "R10 no ack after stop", ack, 0);
    mStop();
    mSda = 1'b0; repeat (2) @(negedge clk);
    mSda = 1'b1; waitQ();
    mScl = 1'b0; waitQ();
    mWrite({OWN, 1'b0}, ack);
    chk(!ack, "R11 glitch not a start", ack, 0);
    mStop();
    mStart(); mWrite({OWN, 1'b0}, ack); mStop();
    chk(ack, "R11 real start still works", ack, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) txData[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testWrite();
    testMiss();
    testRead();
    testGenCall();
    testStretch();
    testOverflow();
    testIdle();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule